// File: doc/BRIEF.md
# Double-Buffered Converter Code Register

This block is the synchronous digital front end of a 12-bit converter that sits on a processor bus. A code reaches the converter through two register stages. The first stage is an input latch made of an 8-bit upper section and a 4-bit lower section. It is written under chip select, a first write strobe and a byte-select line. The second stage is the converter register. A separate pair of strobes, a second write and a transfer, copies the whole latch into it. Because the transfer has its own strobes, several converters can be preloaded one at a time and then updated together by a single shared transfer.

A parameter chooses the data port. The wide variant has twelve data lines with bit 0 as the least significant bit. The narrow variant has an 8-bit bus that carries left-justified data. On the narrow bus the processor sees the block as a two-byte stack: the first write carries the upper eight bits, and the second write carries the lower four bits on the upper half of the bus.

Each control level is sampled on the clock edge. Any input bit that is not a clean 0 (that is, 1, X or Z) is taken as 1, the same way a floating pin would read. Both stages clear to zero on reset. The converter code and the input-latch contents are both brought out as ports.

Top module: `dac_fe_top`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released with no strobes active, the converter code and the latch word are both zero.
- R2: The input latch loads on a clock edge only when `cs_n` and `wr1_n` are both 0 at that edge. In every other case it keeps its value, even when the data lines change.
- R3: During a latch load with `byte_sel` = 1, all 12 latch bits are written. With `byte_sel` = 0, only latch bits 3..0 are written and bits 11..4 keep their value.
- R4: The converter register takes the latch word only when `wr2_n` and `xfer_n` are both 0 at a clock edge. Otherwise it holds, including while the input latch is being rewritten.
- R5: When a latch load and a transfer fall in the same cycle (flow-through), the converter code at that edge becomes the newly loaded latch word.
- R6: On the 8-bit bus, a load puts `din[7:0]` into latch bits 11..4 and `din[7:4]` into latch bits 3..0. A write with `byte_sel`=1 followed by a write with `byte_sel`=0 therefore assembles {first byte, upper nibble of second byte}.
- R7: On the 12-line port, a load with `byte_sel`=1 puts `din[11:0]` into latch bits 11..0 unchanged, with bit 0 as the least significant bit. A load with `byte_sel`=0 writes only `din[3:0]`.
- R8: Each stage changes exactly one clock edge after its enabling strobes are sampled, and never between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Input-latch write strobe, active low |
| byte_sel | input | 1 | 1: write all latch bits; 0: write the lower 4 bits only |
| wr2_n | input | 1 | Transfer enable, active low |
| xfer_n | input | 1 | Transfer strobe, active low |
| din | input | 8 (narrow) or 12 (wide) | Data lines, left-justified |
| dac_code | output | 12 | Converter register contents |
| latch_word | output | 12 | Input latch contents |

## Verification
Both the latch word and the converter code are due one clock edge after the cycle that drives their strobes. The one exception is flow-through: there, the converter code takes the new latch word at that same single edge. The driver changes inputs on the falling edge. For each step it pushes the expected pair for both port variants into a queue. The monitor pops that entry 1 ns after the following rising edge, so every result is compared in the cycle it is due. Hold steps, where strobes are off or half-asserted while the data lines change, are compared at the ports in the same way.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
  localparam int unsigned DEF_CODE_W = 12;
  localparam int unsigned DEF_LO_W   = 4;

  typedef struct packed {
    logic cs_n;
    logic wr1_n;
    logic byte_sel;
    logic wr2_n;
    logic xfer_n;
  } dac_fe_ctl_t;

  localparam int unsigned CTL_W = $bits(dac_fe_ctl_t);
endpackage

// File: rtl/dac_fe_pin_cond.sv
module dac_fe_pin_cond #(
  parameter int unsigned W = 1
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] clean
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      if (raw[b] === 1'b0) clean[b] = 1'b0;
      else                 clean[b] = 1'b1;
    end
  end
endmodule

// File: rtl/dac_fe_in_latch.sv
module dac_fe_in_latch #(
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned LO_W       = 4,
  parameter bit          NARROW_BUS = 1'b1,
  parameter int unsigned BUS_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              byte_sel,
  input  logic [BUS_W-1:0]  din,
  output logic [CODE_W-1:0] word_q,
  output logic [CODE_W-1:0] word_nxt
);
  localparam int unsigned HI_W = CODE_W - LO_W;

  logic [HI_W-1:0] hi_src, hi_q, hi_nxt;
  logic [LO_W-1:0] lo_src, lo_q, lo_nxt;

  if (NARROW_BUS) begin : g_narrow
    assign hi_src = din[HI_W-1:0];
    assign lo_src = din[BUS_W-1 -: LO_W];
  end else begin : g_wide
    assign hi_src = din[CODE_W-1:LO_W];
    assign lo_src = din[LO_W-1:0];
  end

  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (load_en) begin
      lo_nxt = lo_src;
      if (byte_sel) hi_nxt = hi_src;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assign word_q   = {hi_q, lo_q};
  assign word_nxt = {hi_nxt, lo_nxt};

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(word_q));

  // R3
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !byte_sel) |=> $stable(hi_q));

  // R7
  lower_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (lo_q == $past(lo_src)));
endmodule

// File: rtl/dac_fe_xfer_reg.sv
module dac_fe_xfer_reg #(
  parameter int unsigned CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_en,
  input  logic [CODE_W-1:0] src_word,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_nxt;

  always_comb begin
    code_nxt = code_q;
    if (xfer_en) code_nxt = src_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_nxt;
  end

  // R4
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en |=> $stable(code_q));
endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top
  import dac_fe_pkg::*;
#(
  parameter int unsigned CODE_W     = DEF_CODE_W,
  parameter int unsigned LO_W       = DEF_LO_W,
  parameter bit          NARROW_BUS = 1'b1
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            cs_n,
  input  logic                                            wr1_n,
  input  logic                                            byte_sel,
  input  logic                                            wr2_n,
  input  logic                                            xfer_n,
  input  logic [(NARROW_BUS ? CODE_W-LO_W : CODE_W)-1:0]  din,
  output logic [CODE_W-1:0]                               dac_code,
  output logic [CODE_W-1:0]                               latch_word
);
  localparam int unsigned BUS_W = NARROW_BUS ? CODE_W - LO_W : CODE_W;

  dac_fe_ctl_t       ctl_raw, ctl;
  logic [BUS_W-1:0]  din_c;
  logic [CODE_W-1:0] latch_nxt;
  logic              load_en, xfer_en;

  assign ctl_raw = '{cs_n: cs_n, wr1_n: wr1_n, byte_sel: byte_sel,
                     wr2_n: wr2_n, xfer_n: xfer_n};

  dac_fe_pin_cond #(.W(CTL_W)) i_ctl_cond (.raw(ctl_raw), .clean(ctl));
  dac_fe_pin_cond #(.W(BUS_W)) i_din_cond (.raw(din),     .clean(din_c));

  assign load_en = !ctl.cs_n  && !ctl.wr1_n;
  assign xfer_en = !ctl.wr2_n && !ctl.xfer_n;

  dac_fe_in_latch #(
    .CODE_W(CODE_W), .LO_W(LO_W), .NARROW_BUS(NARROW_BUS), .BUS_W(BUS_W)
  ) i_latch (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .byte_sel(ctl.byte_sel),
    .din(din_c), .word_q(latch_word), .word_nxt(latch_nxt)
  );

  dac_fe_xfer_reg #(.CODE_W(CODE_W)) i_xfer (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en),
    .src_word(latch_nxt), .code_q(dac_code)
  );

  // R5
  flow_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && xfer_en) |=> (dac_code == latch_word));

  // R4
  xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && !load_en) |=> (dac_code == $past(latch_word)));
endmodule

// File: tb/test_dac_fe_top.sv
`timescale 1ns/1ps
module test_dac_fe_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr1_n = 1'b1, byte_sel = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1;
  logic [7:0]  din_n = '0;
  logic [11:0] din_w = '0;
  logic [11:0] code_n, latch_n, code_w, latch_w;

  typedef struct {
    logic [11:0] code_n, latch_n, code_w, latch_w;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [11:0] m_code_n = '0, m_latch_n = '0, m_code_w = '0, m_latch_w = '0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  dac_fe_top #(.NARROW_BUS(1'b1)) i_dac_fe_top (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .byte_sel(byte_sel),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .din(din_n),
    .dac_code(code_n), .latch_word(latch_n));

  dac_fe_top #(.NARROW_BUS(1'b0)) i_dac_fe_top_w (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr1_n(wr1_n), .byte_sel(byte_sel),
    .wr2_n(wr2_n), .xfer_n(xfer_n), .din(din_w),
    .dac_code(code_w), .latch_word(latch_w));

  task automatic cmp(input logic [11:0] act, input logic [11:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w1, input logic bs, input logic w2,
                      input logic xf, input logic [7:0] dn, input logic [11:0] dw,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cs_n = c; wr1_n = w1; byte_sel = bs; wr2_n = w2; xfer_n = xf;
    din_n = dn; din_w = dw;
    if (!c && !w1) begin
      m_latch_n[3:0] = dn[7:4];
      m_latch_w[3:0] = dw[3:0];
      if (bs) begin
        m_latch_n[11:4] = dn;
        m_latch_w[11:4] = dw[11:4];
      end
    end
    if (!w2 && !xf) begin
      m_code_n = m_latch_n;
      m_code_w = m_latch_w;
    end
    e.code_n = m_code_n; e.latch_n = m_latch_n;
    e.code_w = m_code_w; e.latch_w = m_latch_w; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: results due one rising edge after the driving falling edge (R8)
  always begin
    @(posedge clk);
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      cmp(latch_n, e.latch_n, {e.tag, " narrow latch"});
      cmp(code_n,  e.code_n,  {e.tag, " narrow code"});
      cmp(latch_w, e.latch_w, {e.tag, " wide latch"});
      cmp(code_w,  e.code_w,  {e.tag, " wide code"});
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cmp(code_n, 12'h000, "R1 reset narrow code");
    cmp(latch_w, 12'h000, "R1 reset wide latch");
    rst_n = 1'b1;
    step(1, 1, 1, 1, 1, 8'hFF, 12'hFFF, "R1 idle after reset");
    step(0, 0, 1, 1, 1, 8'hA5, 12'h3C7, "R6 R7 first byte");
    step(1, 1, 1, 1, 1, 8'h11, 12'h111, "R2 no strobe hold");
    step(1, 0, 1, 1, 1, 8'h22, 12'h222, "R2 cs high hold");
    step(0, 1, 1, 1, 1, 8'h33, 12'h333, "R2 wr1 high hold");
    step(0, 0, 0, 1, 1, 8'h9E, 12'hF5B, "R3 R6 second byte");
    step(1, 1, 1, 0, 0, 8'h00, 12'h000, "R4 transfer");
    step(0, 0, 1, 1, 1, 8'h5C, 12'h8E1, "R4 write without transfer");
    step(0, 0, 0, 0, 1, 8'h70, 12'h00F, "R4 wr2 only no transfer");
    step(1, 1, 1, 1, 0, 8'h00, 12'h000, "R4 xfer only no transfer");
    step(1, 1, 1, 0, 0, 8'h00, 12'h000, "R4 R6 transfer assembled");
    step(0, 0, 1, 0, 0, 8'hC3, 12'h6D2, "R5 flow through full");
    step(0, 0, 0, 0, 0, 8'h40, 12'hABC, "R5 R3 flow through low");
    step(0, 0, 1, 1, 1, 8'hFF, 12'hFFF, "R7 all ones");
    step(0, 0, 1, 0, 0, 8'h00, 12'h000, "R5 R7 all zeros");
    step(1, 1, 1, 1, 1, 8'h00, 12'h000, "R8 idle end");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule